// File: doc/BRIEF.md
# Flagged Integer Adder with Saturation

This block is a two-operand integer add/subtract unit with condition flags. It runs either on the full data width (32 bits by default) or on a narrow half width (16 bits by default). A 2-bit operation code picks one of four operations: plain addition, subtraction, reverse subtraction, or addition that folds in an incoming carry bit. A saturate enable replaces a signed-overflowed result with the nearest representable signed extreme.

All four operations share one adder. Each operand may be inverted on the way in, and the adder's carry input comes from a constant or from the incoming carry bit. The unit returns the result together with four flags: carry, signed overflow, sign and zero.

When the `OUT_REG` parameter is 1, the result and flags pass through a single register stage, so they appear one clock after the inputs. When `OUT_REG` is 0, the outputs follow the inputs combinationally and the clock and reset are used only by the attached checker.

Top module: `adder_flagged`

## Requirements
- R1: `op` selects the operation: 2'b00 gives A+B, 2'b01 gives A−B (computed as A+~B+1), 2'b10 gives B−A (computed as ~A+B+1), and 2'b11 gives A+B+`carry_in`.
- R2: `flag_c` is the bit just above the active width (bit 16 in narrow mode, bit 32 in wide mode) of the unbounded sum of the two adder inputs, taken after any inversion, plus the adder carry input.
- R3: `flag_v` is 1 exactly when the two adder inputs, after inversion, have equal sign bits and the wrapped sum has a different sign bit.
- R4: When `sat_en` is 1 and overflow occurs, a wrapped sum whose sign bit is set is replaced by the largest positive value (0x7FFF or 0x7FFFFFFF). A wrapped sum whose sign bit is clear is replaced by the most negative value (0x8000 or 0x80000000).
- R5: `flag_n` equals the sign bit of the final result and `flag_z` is 1 when the final result is zero. Both are taken after saturation.
- R6: When `wide` is 0, the sign bit is bit 15, bits 31:16 of both sources have no effect on any output, and bits 31:16 of `result` are zero. When `wide` is 1, the sign bit is bit 31.
- R7: When saturation changes the result, `flag_c` and `flag_v` still describe the unsaturated sum.
- R8: With `OUT_REG`=1, the outputs show the operation presented before the previous rising clock edge. While `rst_n` is low, `result` is 0, `flag_z` is 1 and the other flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Active-low asynchronous reset |
| op | input | 2 | Operation code (00 add, 01 sub, 10 reverse sub, 11 add with carry) |
| wide | input | 1 | 1 selects full width, 0 selects half width |
| sat_en | input | 1 | Saturate on signed overflow |
| carry_in | input | 1 | Incoming carry used by op 11 |
| src_a | input | DATA_W | First source operand |
| src_b | input | DATA_W | Second source operand |
| result | output | DATA_W | Final result |
| flag_c | output | 1 | Carry out of the active width |
| flag_v | output | 1 | Signed overflow of the unsaturated sum |
| flag_n | output | 1 | Sign of the final result |
| flag_z | output | 1 | Final result is zero |

## Verification
Saturation and flag generation act in the same cycle whenever an operation overflows with `sat_en` set. In that cycle the carry and overflow flags must describe the wrapped sum, while the sign and zero flags must describe the clamped value. The bench provokes this case with operands at the signed extremes of both widths (for example 0x7FFF+1 narrow and 0x80000000−1 wide) and with random operands biased towards those extremes. It judges every output field separately against a reference function that computes the unsaturated flags before it clamps.

// File: rtl/adder_flagged_pkg.sv
package adder_flagged_pkg;
   typedef enum logic [1:0] {
      OP_ADD  = 2'b00,
      OP_SUB  = 2'b01,
      OP_RSUB = 2'b10,
      OP_ADDC = 2'b11
   } addop_e;
endpackage

// File: rtl/adder_flagged_prep.sv
// Operand conditioning: optional inversion, narrow-mode masking, carry pick.
module adder_flagged_prep
   import adder_flagged_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic [1:0]        op,
   input  logic              wide,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] add_x,
   output logic [DATA_W-1:0] add_y,
   output logic              add_cin
);
   localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

   logic inv_a, inv_b;
   logic [DATA_W-1:0] keep;

   always_comb begin
      inv_a   = 1'b0;
      inv_b   = 1'b0;
      add_cin = 1'b0;
      unique case (addop_e'(op))
         OP_ADD:  add_cin = 1'b0;
         OP_SUB:  begin inv_b = 1'b1; add_cin = 1'b1; end
         OP_RSUB: begin inv_a = 1'b1; add_cin = 1'b1; end
         OP_ADDC: add_cin = carry_in;
         default: add_cin = 1'b0;
      endcase
   end

   assign keep  = wide ? {DATA_W{1'b1}} : LO_MASK;
   assign add_x = (inv_a ? ~src_a : src_a) & keep;
   assign add_y = (inv_b ? ~src_b : src_b) & keep;
endmodule

// File: rtl/adder_flagged_core.sv
// Single shared adder; narrow-mode carry appears at bit HALF_W because
// upper input bits are already zeroed.
module adder_flagged_core #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] add_x,
   input  logic [DATA_W-1:0] add_y,
   input  logic              add_cin,
   output logic [DATA_W:0]   sum
);
   assign sum = {1'b0, add_x} + {1'b0, add_y} + {{DATA_W{1'b0}}, add_cin};
endmodule

// File: rtl/adder_flagged_sat.sv
// Width selection, overflow detection, clamping and flag generation.
module adder_flagged_sat #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16
) (
   input  logic              wide,
   input  logic              sat_en,
   input  logic [DATA_W-1:0] add_x,
   input  logic [DATA_W-1:0] add_y,
   input  logic [DATA_W:0]   sum,
   output logic [DATA_W-1:0] res,
   output logic              c,
   output logic              v,
   output logic              n,
   output logic              z
);
   localparam logic [DATA_W-1:0] LO_MASK  = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
   localparam logic [DATA_W-1:0] W_MAXPOS = {1'b0, {(DATA_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] N_MAXPOS = LO_MASK >> 1;

   logic [DATA_W-1:0] wrapped, maxpos, minneg;
   logic sx, sy, sr;

   assign wrapped = wide ? sum[DATA_W-1:0] : (sum[DATA_W-1:0] & LO_MASK);
   assign sx      = wide ? add_x[DATA_W-1] : add_x[HALF_W-1];
   assign sy      = wide ? add_y[DATA_W-1] : add_y[HALF_W-1];
   assign sr      = wide ? sum[DATA_W-1]   : sum[HALF_W-1];
   assign c       = wide ? sum[DATA_W]     : sum[HALF_W];
   assign v       = (sx == sy) && (sr != sx);
   assign maxpos  = wide ? W_MAXPOS : N_MAXPOS;
   assign minneg  = maxpos + 1'b1;

   always_comb begin
      res = wrapped;
      if (sat_en && v) res = sr ? maxpos : minneg;
   end

   assign n = wide ? res[DATA_W-1] : res[HALF_W-1];
   assign z = (res == '0);
endmodule

// File: rtl/adder_flagged.sv
module adder_flagged #(
   parameter int DATA_W  = 32,
   parameter int HALF_W  = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        op,
   input  logic              wide,
   input  logic              sat_en,
   input  logic              carry_in,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] result,
   output logic              flag_c,
   output logic              flag_v,
   output logic              flag_n,
   output logic              flag_z
);
   if (HALF_W < 2 || HALF_W >= DATA_W) begin : g_bad_width
      $error("adder_flagged: HALF_W must be in [2, DATA_W-1]");
   end

   logic [DATA_W-1:0] add_x, add_y, res_c;
   logic [DATA_W:0]   sum;
   logic              add_cin, c_c, v_c, n_c, z_c;

   adder_flagged_prep #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_prep (
      .op(op), .wide(wide), .carry_in(carry_in), .src_a(src_a), .src_b(src_b),
      .add_x(add_x), .add_y(add_y), .add_cin(add_cin)
   );

   adder_flagged_core #(.DATA_W(DATA_W)) u_core (
      .add_x(add_x), .add_y(add_y), .add_cin(add_cin), .sum(sum)
   );

   adder_flagged_sat #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_sat (
      .wide(wide), .sat_en(sat_en), .add_x(add_x), .add_y(add_y), .sum(sum),
      .res(res_c), .c(c_c), .v(v_c), .n(n_c), .z(z_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result <= '0;
            flag_c <= 1'b0;
            flag_v <= 1'b0;
            flag_n <= 1'b0;
            flag_z <= 1'b1;
         end else begin
            result <= res_c;
            flag_c <= c_c;
            flag_v <= v_c;
            flag_n <= n_c;
            flag_z <= z_c;
         end
      end
   end else begin : g_comb
      assign result = res_c;
      assign flag_c = c_c;
      assign flag_v = v_c;
      assign flag_n = n_c;
      assign flag_z = z_c;
   end
endmodule

// File: rtl/adder_flagged_chk.sv
module adder_flagged_chk #(
   parameter int DATA_W = 32,
   parameter int HALF_W = 16,
   parameter bit LAT    = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        op,
   input logic              wide,
   input logic              sat_en,
   input logic [DATA_W-1:0] src_a,
   input logic [DATA_W-1:0] src_b,
   input logic [DATA_W-1:0] result,
   input logic              flag_c,
   input logic              flag_v,
   input logic              flag_n,
   input logic              flag_z
);
   localparam logic [DATA_W-1:0] LO_MASK = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

   logic [1:0]        k_op;
   logic              k_wide, k_sat;
   logic [DATA_W-1:0] k_a, k_b;

   if (LAT) begin : g_align
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            k_op <= '0; k_wide <= 1'b0; k_sat <= 1'b0; k_a <= '0; k_b <= '0;
         end else begin
            k_op <= op; k_wide <= wide; k_sat <= sat_en; k_a <= src_a; k_b <= src_b;
         end
      end
   end else begin : g_direct
      assign k_op = op; assign k_wide = wide; assign k_sat = sat_en;
      assign k_a = src_a; assign k_b = src_b;
   end

   logic [HALF_W:0] n_add;
   logic [DATA_W:0] w_add;
   logic            top_r, top_a;
   assign n_add = {1'b0, k_a[HALF_W-1:0]} + {1'b0, k_b[HALF_W-1:0]};
   assign w_add = {1'b0, k_a} + {1'b0, k_b};
   assign top_r = k_wide ? result[DATA_W-1] : result[HALF_W-1];
   assign top_a = k_wide ? k_a[DATA_W-1]    : k_a[HALF_W-1];

   // R2: plain add without saturation gives carry:sum of the operands
   a_r2_add_sum: assert property (@(posedge clk) disable iff (!rst_n)
      (k_op == 2'b00 && !k_sat) |->
         (k_wide ? ({flag_c, result} == w_add)
                 : ({flag_c, result[HALF_W-1:0]} == n_add)));

   // R3: overflow on add flips the result sign away from the operand sign
   a_r3_add_ovf_sign: assert property (@(posedge clk) disable iff (!rst_n)
      (k_op == 2'b00 && !k_sat && flag_v) |-> (top_r != top_a));

   // R4: saturated result is one of the two extremes of the active width
   a_r4_sat_clamp: assert property (@(posedge clk) disable iff (!rst_n)
      (k_sat && flag_v) |->
         (k_wide ? (result == {1'b0, {(DATA_W-1){1'b1}}} || result == {1'b1, {(DATA_W-1){1'b0}}})
                 : (result == (LO_MASK >> 1) || result == ((LO_MASK >> 1) + 1'b1))));

   // R5: sign and zero flags describe the final result
   a_r5_sign_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_n == top_r) && (flag_z == (result == '0)));

   // R6: narrow mode leaves the upper result bits at zero
   a_r6_narrow_upper: assert property (@(posedge clk) disable iff (!rst_n)
      !k_wide |-> ((result & ~LO_MASK) == '0));
endmodule

bind adder_flagged adder_flagged_chk #(
   .DATA_W(DATA_W), .HALF_W(HALF_W), .LAT(OUT_REG)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .sat_en(sat_en),
   .src_a(src_a), .src_b(src_b), .result(result), .flag_c(flag_c),
   .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
);

// File: tb/adder_flagged_test.sv
module adder_flagged_test;
   localparam int CLK_PERIOD = 10;
   localparam int NRAND      = 3000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  op = '0;
   logic        wide = 1'b0, sat_en = 1'b0, carry_in = 1'b0;
   logic [31:0] src_a = '0, src_b = '0;
   logic [31:0] result;
   logic        flag_c, flag_v, flag_n, flag_z;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   adder_flagged uut (
      .clk(clk), .rst_n(rst_n), .op(op), .wide(wide), .sat_en(sat_en),
      .carry_in(carry_in), .src_a(src_a), .src_b(src_b), .result(result),
      .flag_c(flag_c), .flag_v(flag_v), .flag_n(flag_n), .flag_z(flag_z)
   );

   // returns {c, v, n, z, result[31:0]}
   function automatic logic [35:0] model(input logic [1:0] o, input logic w,
         input logic s, input logic ci, input logic [31:0] a, input logic [31:0] b);
      int width = w ? 32 : 16;
      longint unsigned mask = w ? 64'hFFFF_FFFF : 64'hFFFF;
      longint unsigned x = a & mask, y = b & mask, cc = 0, tot, r;
      logic c, v, sx, sy, sr;
      case (o)
         2'b01: begin y = ~y & mask; cc = 1; end
         2'b10: begin x = ~x & mask; cc = 1; end
         2'b11: cc = ci;
         default: cc = 0;
      endcase
      tot = x + y + cc;
      c  = tot[width];
      r  = tot & mask;
      sx = x[width-1]; sy = y[width-1]; sr = r[width-1];
      v  = (sx == sy) && (sr != sx);
      if (s && v) r = sr ? (mask >> 1) : ((mask >> 1) + 1);
      return {c, v, r[width-1], (r == 0), r[31:0]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, got, exp);
      end
   endtask

   // drive at negedge, sample at the following negedge (one register in between)
   task automatic run(input logic [1:0] o, input logic w, input logic s,
         input logic ci, input logic [31:0] a, input logic [31:0] b, input string tag);
      logic [35:0] e;
      @(negedge clk);
      op = o; wide = w; sat_en = s; carry_in = ci; src_a = a; src_b = b;
      e = model(o, w, s, ci, a, b);
      @(negedge clk);
      chk({tag, " R1 result"}, result, e[31:0]);
      chk({tag, " R2 carry"},  {31'd0, flag_c}, {31'd0, e[35]});
      chk({tag, " R3 overflow"}, {31'd0, flag_v}, {31'd0, e[34]});
      chk({tag, " R5 sign"},  {31'd0, flag_n}, {31'd0, e[33]});
      chk({tag, " R5 zero"},  {31'd0, flag_z}, {31'd0, e[32]});
   endtask

   function automatic logic [31:0] pick();
      case ($urandom_range(0, 7))
         0: return 32'h7FFF_FFFF;
         1: return 32'h8000_0000;
         2: return {$urandom_range(0, 65535), 16'h7FFF};
         3: return {$urandom_range(0, 65535), 16'h8000};
         4: return 32'hFFFF_FFFF;
         5: return 32'h0;
         default: return $urandom;
      endcase
   endfunction

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      // R8 reset state
      chk("R8 reset result", result, 32'h0);
      chk("R8 reset zero flag", {31'd0, flag_z}, 32'd1);
      chk("R8 reset other flags", {29'd0, flag_c, flag_v, flag_n}, 32'd0);
      rst_n = 1'b1;

      // R1 each operation, wide
      run(2'b00, 1, 0, 0, 32'd5, 32'd3, "R1 add");
      run(2'b01, 1, 0, 0, 32'd5, 32'd3, "R1 sub");
      run(2'b10, 1, 0, 0, 32'd5, 32'd3, "R1 rsub");
      run(2'b11, 1, 0, 1, 32'd5, 32'd3, "R1 addc");
      run(2'b01, 1, 0, 0, 32'd9, 32'd9, "R2 sub equal carry zero");
      // R4 / R7 saturation at both widths, both directions
      run(2'b00, 1, 1, 0, 32'h7FFF_FFFF, 32'd1, "R4 R7 wide pos clamp");
      run(2'b01, 1, 1, 0, 32'h8000_0000, 32'd1, "R4 R7 wide neg clamp");
      run(2'b00, 0, 1, 0, 32'hABCD_7FFF, 32'h1234_0001, "R4 R7 narrow pos clamp");
      run(2'b10, 0, 1, 0, 32'h0000_0001, 32'h0000_8000, "R4 R7 narrow neg clamp");
      run(2'b00, 1, 1, 0, 32'h8000_0000, 32'h8000_0000, "R4 R7 wide neg+neg");
      // R6 upper bits ignored in narrow mode
      run(2'b00, 0, 0, 0, 32'hFFFF_0001, 32'h5555_FFFF, "R6 narrow carry");
      run(2'b11, 0, 0, 1, 32'hDEAD_FFFF, 32'hBEEF_0000, "R6 narrow addc");
      @(negedge clk);
      op = 2'b00; wide = 0; sat_en = 0; src_a = 32'hFFFF_0000; src_b = 32'h0F0F_0000;
      @(negedge clk);
      chk("R6 upper only zero result", result, 32'h0);
      chk("R6 upper only zero flag", {31'd0, flag_z}, 32'd1);
      // R8 latency: change inputs just before edge, output follows after it
      @(negedge clk);
      src_a = 32'd100; src_b = 32'd1; wide = 1;
      @(posedge clk); #1;
      chk("R8 after edge", result, 32'd101);

      for (int i = 0; i < NRAND; i++)
         run(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             1'($urandom_range(0, 1)), pick(), pick(), "R1 random");
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (100000) @(posedge clk);
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule